// File: doc/BRIEF.md
# Edge/Level Interrupt Aggregator

This block gathers up to 32 interrupt request lines into one interrupt line for a small management processor. Sixteen lines are internal sources. Up to sixteen more are external sources. Every line first passes a polarity stage, so an active-low request is turned into an active-high one. A capture stage then records the event in a sticky status bit. In edge mode that happens only when the normalised line rises. In level mode it happens whenever the normalised line is high.

A per-bit enable register masks status into a pending view. The interrupt line is high while any pending bit is set. Software reads status, pending and enable through a simple 32-bit register port. It drops captured events by writing ones to an acknowledge register. A level source that is still active cannot be acknowledged away: its bit comes back in the same update.

The trigger mode and polarity of the external lines are build-time parameters. The internal lines are fixed to rising-edge, active-high.

Top module: `irq_aggregator`

## Requirements
- R1: Reading byte offset 0x34 returns status AND enable. Status is read at 0x30, enable at 0x38 and acknowledge at 0x3C. Any other offset reads zero.
- R2: `irq_out` is high exactly when status AND enable is non-zero. It reflects each register update right after the clock edge that makes it.
- R3: An external line whose bit in `EXT_POS_MASK` is 0 is active-low. Driving it low counts as an asserted request.
- R4: An edge-mode line sets its status bit only on the clock edge where its normalised level is high and was low at the previous edge. Holding it high sets nothing further.
- R5: A level-mode line sets its status bit at every clock edge where its normalised level is high.
- R6: Lines 0 to 15 are always rising-edge, active-high. External line k appears at status bit 16+k. It uses bit k of `EXT_EDGE_MASK` (1 = edge, 0 = level) and bit k of `EXT_POS_MASK` (1 = active-high).
- R7: A write to 0x3C clears exactly those status bits that are written as 1. Bits written as 0 are kept.
- R8: A level-mode line that is still active when its bit is acknowledged keeps its status bit set at that same edge.
- R9: A write to 0x38 loads enable at that clock edge. The pending view and `irq_out` follow at once.
- R10: Bits set in mask 0x40008787 are never set in status or enable, and read as zero at 0x30, 0x34 and 0x38.
- R11: Writes to 0x30 and 0x34 change no register.
- R12: After reset, status, enable and the stored previous levels are zero, and `irq_out` is low. Offset 0x3C always reads zero.
- R13: An edge capture and an acknowledge of the same bit at the same clock edge leave that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 16+EXT_COUNT | Raw request lines; bit 16+k is external line k |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wen | input | 1 | Write strobe, one write per clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
Two functions can land on the same edge: a new capture of a bit, and an acknowledge write that clears that bit. The bench provokes this on purpose in two ways. It raises an edge-mode line in the very cycle its set bit is acknowledged. It also acknowledges a level line while the line is still held active. In both cases the bit must stay set. Random traffic mixes acknowledge and enable writes with toggling inputs on every cycle. A reference model, applied in the order clear-then-capture, judges each cycle's readback and the interrupt line.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned INT_LINES  = 16;
    localparam logic [REG_W-1:0] RSVD_BITS = 32'h4000_8787;

    localparam logic [7:0] OFF_STATUS  = 8'h30;
    localparam logic [7:0] OFF_PENDING = 8'h34;
    localparam logic [7:0] OFF_ENABLE  = 8'h38;
    localparam logic [7:0] OFF_ACK     = 8'h3C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_PENDING,
        SEL_ENABLE,
        SEL_ACK
    } reg_sel_e;

    function automatic reg_sel_e decode_off(input logic [7:0] off);
        unique case (off)
            OFF_STATUS:  return SEL_STATUS;
            OFF_PENDING: return SEL_PENDING;
            OFF_ENABLE:  return SEL_ENABLE;
            OFF_ACK:     return SEL_ACK;
            default:     return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irq_src_frontend.sv
module irq_src_frontend
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter logic [REG_W-1:0] EDGE_BITS = '1,
    parameter logic [REG_W-1:0] POS_BITS  = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raw_i,
    output logic [REG_W-1:0]   norm_o,
    output logic [REG_W-1:0]   prev_o,
    output logic [REG_W-1:0]   cap_o
);
    for (genvar i = 0; i < REG_W; i++) begin : g_line
        if (i < NUM_SRC) begin : g_live
            logic lvl;
            logic prev_q;
            if (POS_BITS[i]) begin : g_high
                assign lvl = raw_i[i];
            end else begin : g_low
                assign lvl = ~raw_i[i];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= lvl;
            end

            if (EDGE_BITS[i]) begin : g_edge
                assign cap_o[i] = lvl & ~prev_q;
            end else begin : g_level
                assign cap_o[i] = lvl;
            end
            assign norm_o[i] = lvl;
            assign prev_o[i] = prev_q;
        end else begin : g_absent
            assign norm_o[i] = 1'b0;
            assign prev_o[i] = 1'b0;
            assign cap_o[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_agg_pkg::*;
#(
    parameter logic [REG_W-1:0] KEEP_BITS = ~RSVD_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] cap_i,
    input  logic [REG_W-1:0] ack_i,
    output logic [REG_W-1:0] status_o
);
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] status_d;

    // Clear first, then capture: an event in the same cycle survives.
    always_comb begin
        status_d = ((status_q & ~ack_i) | cap_i) & KEEP_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status_o = status_q;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_agg_pkg::*;
#(
    parameter logic [REG_W-1:0] KEEP_BITS = ~RSVD_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       addr_i,
    input  logic             wen_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [REG_W-1:0] status_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [REG_W-1:0] ack_o,
    output logic [REG_W-1:0] enable_o,
    output logic [REG_W-1:0] pending_o
);
    reg_sel_e         sel;
    logic [REG_W-1:0] enable_q;

    assign sel = decode_off(addr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             enable_q <= '0;
        else if (wen_i && (sel == SEL_ENABLE)) enable_q <= wdata_i & KEEP_BITS;
    end

    assign ack_o     = (wen_i && (sel == SEL_ACK)) ? wdata_i : '0;
    assign enable_o  = enable_q;
    assign pending_o = status_i & enable_q;

    always_comb begin
        unique case (sel)
            SEL_STATUS:  rdata_o = status_i;
            SEL_PENDING: rdata_o = pending_o;
            SEL_ENABLE:  rdata_o = enable_q;
            default:     rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned EXT_COUNT     = 16,
    parameter logic [15:0] EXT_EDGE_MASK = 16'h00FF,
    parameter logic [15:0] EXT_POS_MASK  = 16'h0F0F
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [INT_LINES+EXT_COUNT-1:0] irq_in,
    input  logic [7:0]                    bus_addr,
    input  logic                          bus_wen,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output logic                          irq_out
);
    localparam int unsigned NUM_SRC = INT_LINES + EXT_COUNT;
    localparam logic [REG_W-1:0] LIVE_BITS =
        (NUM_SRC >= REG_W) ? '1 : ((32'h1 << NUM_SRC) - 32'h1);
    localparam logic [REG_W-1:0] KEEP_MASK = LIVE_BITS & ~RSVD_BITS;
    localparam logic [REG_W-1:0] EDGE_FULL = {EXT_EDGE_MASK, 16'hFFFF};
    localparam logic [REG_W-1:0] POS_FULL  = {EXT_POS_MASK, 16'hFFFF};

    logic [REG_W-1:0] norm_w, prev_w, cap_w, ack_w, stat_w, en_w, pend_w;
    logic [REG_W-1:0] edge_mask_w, keep_mask_w;

    assign edge_mask_w = EDGE_FULL;
    assign keep_mask_w = KEEP_MASK;

    irq_src_frontend #(
        .NUM_SRC(NUM_SRC), .EDGE_BITS(EDGE_FULL), .POS_BITS(POS_FULL)
    ) u_front (
        .clk(clk), .rst_n(rst_n), .raw_i(irq_in),
        .norm_o(norm_w), .prev_o(prev_w), .cap_o(cap_w)
    );

    irq_status_reg #(.KEEP_BITS(KEEP_MASK)) u_stat (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_w), .ack_i(ack_w),
        .status_o(stat_w)
    );

    irq_reg_port #(.KEEP_BITS(KEEP_MASK)) u_port (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wen_i(bus_wen),
        .wdata_i(bus_wdata), .status_i(stat_w), .rdata_o(bus_rdata),
        .ack_o(ack_w), .enable_o(en_w), .pending_o(pend_w)
    );

    assign irq_out = |pend_w;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wen,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        irq_out,
    input logic [31:0] norm,
    input logic [31:0] prev,
    input logic [31:0] stat,
    input logic [31:0] en,
    input logic [31:0] edge_mask,
    input logic [31:0] keep_mask
);
    // R2: line follows the masked status
    a_r2_out_is_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(stat & en)));

    // R4: an edge-mode bit is newly set only after a rising normalised level
    a_r4_edge_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & edge_mask
                   & ~($past(norm) & ~$past(prev))) == 32'h0));

    // R8: an active level-mode line always leaves its bit set
    a_r8_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(norm) & ~edge_mask & keep_mask) & ~stat) == 32'h0));

    // R10: reserved bits never set
    a_r10_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat | en) & ~keep_mask) == 32'h0);

    // R9: enable loads on its write edge
    a_r9_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == 8'h38) |=> (en == ($past(bus_wdata) & keep_mask)));

    // R11: a status write sets no bit that no input raised
    a_r11_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == 8'h30) |=> ((stat & ~$past(stat) & ~$past(norm)) == 32'h0));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_out(irq_out), .norm(norm_w), .prev(prev_w),
    .stat(stat_w), .en(en_w), .edge_mask(edge_mask_w), .keep_mask(keep_mask_w)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    localparam logic [31:0] RSVD  = 32'h4000_8787;
    localparam logic [31:0] EDGEF = {16'h00FF, 16'hFFFF};
    localparam logic [31:0] POSF  = {16'h0F0F, 16'hFFFF};
    localparam logic [31:0] IDLE  = ~POSF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = IDLE;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_st = '0, m_en = '0, m_prev = '0;

    always #4 clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h30:   return m_st;
            8'h34:   return m_st & m_en;
            8'h38:   return m_en;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        case (a)
            8'h30:   return "R5";
            8'h34:   return "R1";
            8'h38:   return "R9";
            8'h3C:   return "R12";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic [31:0] irq, input logic w,
                              input logic [7:0] a, input logic [31:0] d);
        logic [31:0] nrm, cap, ack;
        nrm = irq ^ ~POSF;
        cap = (EDGEF & nrm & ~m_prev) | (~EDGEF & nrm);
        ack = (w && a == 8'h3C) ? d : 32'h0;
        m_st = ((m_st & ~ack) | cap) & ~RSVD;
        if (w && a == 8'h38) m_en = d & ~RSVD;
        m_prev = nrm;
    endtask

    task automatic tick(input logic [31:0] irq, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
        @(negedge clk);
        irq_in = irq; bus_wen = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step(irq, w, a, d);
        #1;
        check(tag, bus_rdata, model_read(a));
        check("R2", {31'h0, irq_out}, {31'h0, |(m_st & m_en)});
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R12: reset state
        check("R12", {31'h0, irq_out}, 32'h0);
        tick(IDLE, 1'b0, 8'h30, 0, "R12");
        tick(IDLE, 1'b0, 8'h38, 0, "R12");
        tick(IDLE, 1'b0, 8'h3C, 0, "R12");
        // R10: reserved bits never stick in enable
        tick(IDLE, 1'b1, 8'h38, 32'hFFFF_FFFF, "R10");
        tick(IDLE, 1'b0, 8'h38, 0, "R10");
        // R6: internal bit 3 is edge: held high, acked, stays clear
        tick(IDLE | 32'h8, 1'b0, 8'h30, 0, "R6");
        tick(IDLE | 32'h8, 1'b0, 8'h30, 0, "R6");
        tick(IDLE | 32'h8, 1'b1, 8'h3C, 32'h8, "R7");
        tick(IDLE | 32'h8, 1'b0, 8'h30, 0, "R4");
        tick(IDLE, 1'b0, 8'h30, 0, "R4");
        // R3: ext 4 (bit 20) is active-low edge; drive low
        tick(IDLE & ~32'h0010_0000, 1'b0, 8'h30, 0, "R3");
        tick(IDLE, 1'b0, 8'h34, 0, "R3");
        // R7: ack only bit 3 set? clear bit 20 only, keep others
        tick(IDLE | 32'h10, 1'b0, 8'h30, 0, "R6");
        tick(IDLE, 1'b1, 8'h3C, 32'h0010_0000, "R7");
        tick(IDLE, 1'b0, 8'h30, 0, "R7");
        // R8: ext 8 (bit 24) is active-high level; ack while held
        tick(IDLE | 32'h0100_0000, 1'b0, 8'h30, 0, "R5");
        tick(IDLE | 32'h0100_0000, 1'b1, 8'h3C, 32'h0100_0000, "R8");
        tick(IDLE | 32'h0100_0000, 1'b0, 8'h30, 0, "R8");
        tick(IDLE, 1'b1, 8'h3C, 32'h0100_0000, "R8");
        tick(IDLE, 1'b0, 8'h30, 0, "R8");
        // R10: ext 14 (bit 30) is reserved; active-low level asserted
        tick(IDLE & ~32'h4000_0000, 1'b0, 8'h30, 0, "R10");
        tick(IDLE, 1'b0, 8'h34, 0, "R10");
        // R13: ext 0 (bit 16) set, then rises again during its ack
        tick(IDLE | 32'h0001_0000, 1'b0, 8'h30, 0, "R4");
        tick(IDLE, 1'b0, 8'h30, 0, "R4");
        tick(IDLE | 32'h0001_0000, 1'b1, 8'h3C, 32'h0001_0000, "R13");
        tick(IDLE | 32'h0001_0000, 1'b0, 8'h30, 0, "R13");
        // R11: writes to status and pending are inert
        tick(IDLE, 1'b1, 8'h30, 32'h0, "R11");
        tick(IDLE, 1'b1, 8'h34, 32'hFFFF_FFFF, "R11");
        tick(IDLE, 1'b0, 8'h30, 0, "R11");
        // R9: disable all, line drops
        tick(IDLE, 1'b1, 8'h38, 32'h0, "R9");
        // random traffic
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] irq, d;
            logic [7:0]  a;
            logic        w;
            int          op;
            irq = $urandom() & $urandom();
            irq = irq ^ IDLE;
            op  = $urandom_range(0, 9);
            d   = $urandom();
            w   = 1'b0;
            a   = 8'h30;
            case (op)
                0: begin w = 1'b1; a = 8'h38; end
                1, 2: begin w = 1'b1; a = 8'h3C; end
                3: begin w = 1'b1; a = 8'h30; end
                4: a = 8'h34;
                5: a = 8'h38;
                6: a = 8'h3C;
                7: a = 8'h20;
                default: a = 8'h30;
            endcase
            tick(irq, w, a, d, tag_for(a));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule